// File: doc/BRIEF.md
# Reset Source Controller

This block merges every reset request in the chip into one system reset. The requests come from power-on, the supply monitor, the external reset pin, a missing-clock detector, a software trigger and an illegal flash access. After the reset ends, a readable cause word shows what started it. The system reset stays high for a fixed number of clock cycles after the last request goes away. For power-related resets the block also pulls the reset pin low until the reset ends.

The missing-clock detector uses a separate reference clock. That clock runs a ping/echo exchange with the system clock. If no echo comes back for `STUCK_LIMIT` reference cycles, the detector raises a reset request directly, even while the system clock is stopped.

Power-on sets the cause word to "power only" and marks the other causes as not valid by clearing them. A power-on also turns the supply monitor on and selects it as a reset source. Every other reset keeps the monitor state unchanged and clears the missing-clock enable.

Cause word bits (read on `cause_o`):
- bit 0: external pin
- bit 1: power-on or supply monitor
- bit 2: stopped clock
- bit 3: software
- bit 4: flash error
- bits 7:5: read 0

Source-control write (`wr_sel_i`=0):
- bit 1: monitor-select
- bit 2: clock-detector enable
- bit 3: software reset when 1

Monitor write (`wr_sel_i`=1):
- bit 7: monitor enable

Top module: `rst_source_ctrl`

## Requirements
- R1: While `por_i` is high, `sys_rst_o` and `pin_drive_o` are 1 and `cause_o` is 0. After the power-on reset ends, `cause_o` is 0x02 and `mon_en_o` is 1, even if the monitor was disabled before.
- R2: A single-cycle software request holds `sys_rst_o` high for exactly `HOLD_CYCLES` consecutive cycles.
- R3: A low level on `rst_pin_n_i` causes a reset that leaves `cause_o` = 0x01 and never asserts `pin_drive_o`.
- R4: When the monitor is enabled and selected and `pwr_ok_i` goes low, a reset follows. During it `pin_drive_o` is 1, and afterwards `cause_o` is 0x02. When monitor-select is 0, a low `pwr_ok_i` causes no reset.
- R5: If the detector is enabled and the system clock stops for more than `STUCK_LIMIT` reference cycles, `sys_rst_o` goes high while the clock is still stopped. `pin_drive_o` stays 0, and afterwards `cause_o` is 0x04.
- R6: Writing bit 2 = 1 enables the detector. Every reset clears the enable, so a stopped clock after a reset causes no reset.
- R7: Writing bit 3 = 1 in the source-control word causes a reset that leaves `cause_o` = 0x08.
- R8: A `flash_wr_i` strobe while `mon_en_o` is 0 causes a reset with `cause_o` = 0x10. While `mon_en_o` is 1, the strobe has no effect.
- R9: A monitor write (`wr_sel_i`=1) loads bit 7 into `mon_en_o`. Non-power-on resets leave `mon_en_o` unchanged.
- R10: Register writes made while `sys_rst_o` is high are ignored.
- R11: Causes seen during one reset episode are ORed together, but a power-on alone sets bit 1 and clears all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ref_clk | input | 1 | Reference clock for the missing-clock detector |
| por_i | input | 1 | Power-on indication, active high, also master reset |
| pwr_ok_i | input | 1 | Supply monitor output, 1 = supply above threshold |
| rst_pin_n_i | input | 1 | External reset pin level, active low |
| flash_wr_i | input | 1 | Strobe for a flash erase or write attempt |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = source-control word, 1 = monitor word |
| wr_data_i | input | 8 | Register write data |
| sys_rst_o | output | 1 | System reset, active high |
| pin_drive_o | output | 1 | 1 = pull the reset pin low |
| cause_o | output | 8 | Cause word of the last reset |
| mon_en_o | output | 1 | Supply monitor enable |

## Verification
A table drives single causes (pin, software, supply drop) and paired causes in one episode. This separates the per-source cause bits from the OR-accumulation, and separates the sources that pull the pin from those that do not. Directed cases cover the following:
- stopping the system clock with the detector enabled and then disabled, which shows that the enable is cleared by each reset;
- flash strobes with the monitor on and off;
- a supply drop with monitor-select cleared;
- writes issued during a reset;
- a power-on that overlaps a pin request, which shows that power-on dominates and restores the monitor enable.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    localparam int CAUSE_W = 8;

    // cause word bit positions
    localparam int CB_PIN   = 0;
    localparam int CB_PWR   = 1;
    localparam int CB_CLK   = 2;
    localparam int CB_SW    = 3;
    localparam int CB_FLASH = 4;

    // write word bit positions
    localparam int WB_MONSEL = 1;
    localparam int WB_CLKEN  = 2;
    localparam int WB_SWRST  = 3;
    localparam int WB_MONEN  = 7;

    typedef enum logic {
        SEL_SRC = 1'b0,
        SEL_MON = 1'b1
    } wsel_e;

    typedef struct packed {
        logic flash;
        logic sw;
        logic clk;
        logic mon;
        logic pin;
        logic por;
    } cause_t;

    // power-on overrides every other cause
    function automatic logic [CAUSE_W-1:0] cause_word(cause_t c);
        logic [CAUSE_W-1:0] w;
        w = '0;
        if (c.por) begin
            w[CB_PWR] = 1'b1;
        end else begin
            w[CB_PIN]   = c.pin;
            w[CB_PWR]   = c.mon;
            w[CB_CLK]   = c.clk;
            w[CB_SW]    = c.sw;
            w[CB_FLASH] = c.flash;
        end
        return w;
    endfunction

endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= RST_VAL;
        end else begin
            st_q[0] <= d;
            for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
        end
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/rsc_clk_watch.sv
module rsc_clk_watch #(
    parameter int STUCK_LIMIT = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic por_i,
    input  logic en_i,
    input  logic echo_i,
    output logic ping_o,
    output logic stuck_o
);
    localparam int CW = $clog2(STUCK_LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(STUCK_LIMIT);

    logic          en_s, echo_s;
    logic          ping_q, stuck_q;
    logic [CW-1:0] cnt_q;

    rsc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_en_sync (
        .clk(ref_clk), .rst(por_i), .d(en_i), .q(en_s));
    rsc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_echo_sync (
        .clk(ref_clk), .rst(por_i), .d(echo_i), .q(echo_s));

    // each returned echo proves the system clock is running
    always_ff @(posedge ref_clk) begin
        if (por_i) begin
            ping_q  <= 1'b0;
            cnt_q   <= '0;
            stuck_q <= 1'b0;
        end else if (echo_s == ping_q) begin
            ping_q  <= ~ping_q;
            cnt_q   <= '0;
            stuck_q <= 1'b0;
        end else if (!en_s) begin
            cnt_q   <= '0;
            stuck_q <= 1'b0;
        end else if (cnt_q >= LIM_V) begin
            stuck_q <= 1'b1;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign ping_o  = ping_q;
    assign stuck_o = stuck_q;

    // R5: a stopped-clock request only arises while the detector is enabled
    p_stuck_needs_en_r5: assert property (@(posedge ref_clk) disable iff (por_i)
        $rose(stuck_q) |-> $past(en_s));

    // R5: the request rises only after the full window without an echo
    p_stuck_after_window_r5: assert property (@(posedge ref_clk) disable iff (por_i)
        $rose(stuck_q) |-> $past(cnt_q) >= LIM_V);
endmodule

// File: rtl/rsc_core.sv
module rsc_core
    import rsc_pkg::*;
#(
    parameter int HOLD_CYCLES = 16
) (
    input  logic               clk,
    input  logic               por_i,
    input  logic               pin_n_s,
    input  logic               pwr_ok_s,
    input  logic               stuck_s,
    input  logic               flash_wr_i,
    input  logic               wr_en_i,
    input  logic               wr_sel_i,
    input  logic [7:0]         wr_data_i,
    output logic               in_rst_o,
    output logic               pin_drive_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               mon_en_o,
    output logic               clk_en_o
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYCLES);
    localparam logic [CW-1:0] ONE_V  = CW'(1);

    logic               in_rst_q;
    logic [CW-1:0]      cnt_q;
    cause_t             seen_q;
    cause_t             req;
    logic               any_req;
    logic               mon_en_q, mon_sel_q, clk_en_q;
    logic               sw_q, flash_q;
    logic [CAUSE_W-1:0] cause_q;
    logic               wr_src, wr_mon;
    logic               unused_wr_bits;

    assign unused_wr_bits = ^{wr_data_i[6:4], wr_data_i[0]};

    always_comb begin
        req       = '0;
        req.pin   = ~pin_n_s;
        req.mon   = mon_en_q & mon_sel_q & ~pwr_ok_s;
        req.clk   = stuck_s;
        req.sw    = sw_q;
        req.flash = flash_q;
    end

    assign any_req = |req;
    assign wr_src  = wr_en_i && (wr_sel_i == SEL_SRC);
    assign wr_mon  = wr_en_i && (wr_sel_i == SEL_MON);

    always_ff @(posedge clk) begin
        if (por_i) begin
            in_rst_q  <= 1'b1;
            cnt_q     <= HOLD_V;
            seen_q    <= '0;
            seen_q.por <= 1'b1;
            mon_en_q  <= 1'b1;
            mon_sel_q <= 1'b1;
            clk_en_q  <= 1'b0;
            cause_q   <= '0;
            sw_q      <= 1'b0;
            flash_q   <= 1'b0;
        end else if (any_req) begin
            in_rst_q <= 1'b1;
            cnt_q    <= HOLD_V;
            seen_q   <= cause_t'(seen_q | req);
            clk_en_q <= 1'b0;
            sw_q     <= 1'b0;
            flash_q  <= 1'b0;
        end else if (in_rst_q) begin
            if (cnt_q == ONE_V) begin
                in_rst_q <= 1'b0;
                cnt_q    <= '0;
                cause_q  <= cause_word(seen_q);
                seen_q   <= '0;
            end else begin
                cnt_q <= cnt_q - ONE_V;
            end
        end else begin
            sw_q    <= wr_src && wr_data_i[WB_SWRST];
            flash_q <= flash_wr_i && !mon_en_q;
            if (wr_src) begin
                mon_sel_q <= wr_data_i[WB_MONSEL];
                clk_en_q  <= wr_data_i[WB_CLKEN];
            end
            if (wr_mon) mon_en_q <= wr_data_i[WB_MONEN];
        end
    end

    assign in_rst_o    = in_rst_q;
    assign pin_drive_o = por_i | (in_rst_q & (seen_q.por | seen_q.mon));
    assign cause_o     = cause_q;
    assign mon_en_o    = mon_en_q;
    assign clk_en_o    = clk_en_q;

    // R2: any request (re)loads the full hold count
    p_req_reloads_r2: assert property (@(posedge clk) disable iff (por_i)
        any_req |=> in_rst_q && cnt_q == HOLD_V);

    // R2: release happens only at the end of a request-free count
    p_release_end_r2: assert property (@(posedge clk) disable iff (por_i)
        $fell(in_rst_q) |-> $past(cnt_q) == ONE_V && !$past(any_req));

    // R1: a power-on episode publishes the power-only word
    p_por_word_r1: assert property (@(posedge clk) disable iff (por_i)
        $fell(in_rst_q) && $past(seen_q.por) |-> cause_q == 8'h02);

    // R9: the monitor enable moves only on a monitor write outside reset
    p_mon_en_kept_r9: assert property (@(posedge clk) disable iff (por_i)
        !(wr_mon && !in_rst_q && !any_req) |=> $stable(mon_en_q));

    // R10: control state is frozen while the reset is active
    p_ctrl_frozen_r10: assert property (@(posedge clk) disable iff (por_i)
        in_rst_q |=> $stable(mon_sel_q) && $stable(mon_en_q));

    // R6: the detector enable is off throughout a reset
    p_clk_en_off_r6: assert property (@(posedge clk) disable iff (por_i)
        in_rst_q |=> !clk_en_q);
endmodule

// File: rtl/rst_source_ctrl.sv
module rst_source_ctrl
    import rsc_pkg::*;
#(
    parameter int HOLD_CYCLES = 16,
    parameter int STUCK_LIMIT = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               ref_clk,
    input  logic               por_i,
    input  logic               pwr_ok_i,
    input  logic               rst_pin_n_i,
    input  logic               flash_wr_i,
    input  logic               wr_en_i,
    input  logic               wr_sel_i,
    input  logic [7:0]         wr_data_i,
    output logic               sys_rst_o,
    output logic               pin_drive_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               mon_en_o
);
    logic pin_n_s, pwr_ok_s, stuck_s, echo_s;
    logic ping, stuck_ref, clk_en, in_rst;

    rsc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
        .clk(clk), .rst(por_i), .d(rst_pin_n_i), .q(pin_n_s));
    rsc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pwr_sync (
        .clk(clk), .rst(por_i), .d(pwr_ok_i), .q(pwr_ok_s));
    rsc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_stuck_sync (
        .clk(clk), .rst(por_i), .d(stuck_ref), .q(stuck_s));
    rsc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ping_sync (
        .clk(clk), .rst(por_i), .d(ping), .q(echo_s));

    rsc_clk_watch #(.STUCK_LIMIT(STUCK_LIMIT), .SYNC_STAGES(SYNC_STAGES)) u_watch (
        .ref_clk (ref_clk),
        .por_i   (por_i),
        .en_i    (clk_en),
        .echo_i  (echo_s),
        .ping_o  (ping),
        .stuck_o (stuck_ref)
    );

    rsc_core #(.HOLD_CYCLES(HOLD_CYCLES)) u_core (
        .clk         (clk),
        .por_i       (por_i),
        .pin_n_s     (pin_n_s),
        .pwr_ok_s    (pwr_ok_s),
        .stuck_s     (stuck_s),
        .flash_wr_i  (flash_wr_i),
        .wr_en_i     (wr_en_i),
        .wr_sel_i    (wr_sel_i),
        .wr_data_i   (wr_data_i),
        .in_rst_o    (in_rst),
        .pin_drive_o (pin_drive_o),
        .cause_o     (cause_o),
        .mon_en_o    (mon_en_o),
        .clk_en_o    (clk_en)
    );

    // the stopped-clock request bypasses the system clock domain
    assign sys_rst_o = por_i | in_rst | stuck_ref;

    // R3: pin drive is only ever seen inside a system reset
    p_drive_within_reset_r3: assert property (@(posedge clk) disable iff (por_i)
        pin_drive_o |-> sys_rst_o);
endmodule

// File: tb/tb_rst_source_ctrl.sv
module tb_rst_source_ctrl;
    localparam int HOLD  = 16;
    localparam int LIMIT = 12;

    logic       clk = 1'b0, ref_clk = 1'b0, clk_run = 1'b1;
    logic       por = 1'b1, pwr_ok = 1'b1, pin_n = 1'b1, flash_wr = 1'b0;
    logic       wr_en = 1'b0, wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       sys_rst, pin_drive, mon_en;
    logic [7:0] cause;
    int         checks = 0, errors = 0;

    always begin #4; if (clk_run) clk = ~clk; end
    always #25 ref_clk = ~ref_clk;

    rst_source_ctrl #(.HOLD_CYCLES(HOLD), .STUCK_LIMIT(LIMIT), .SYNC_STAGES(2)) dut (
        .clk(clk), .ref_clk(ref_clk), .por_i(por), .pwr_ok_i(pwr_ok),
        .rst_pin_n_i(pin_n), .flash_wr_i(flash_wr), .wr_en_i(wr_en),
        .wr_sel_i(wr_sel), .wr_data_i(wr_data), .sys_rst_o(sys_rst),
        .pin_drive_o(pin_drive), .cause_o(cause), .mon_en_o(mon_en));

    // op[15:12], expected pin drive at bit 8, expected cause word [7:0]
    localparam logic [15:0] VEC [5] = '{16'h1001, 16'h2008, 16'h3102, 16'h4009, 16'h5103};

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick; @(negedge clk); endtask

    task automatic wr(logic sel, logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick;
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic wait_release(output bit drove, output bit saw);
        drove = 1'b0; saw = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (sys_rst) saw = 1'b1;
            if (pin_drive) drove = 1'b1;
            if (saw && !sys_rst) break;
            tick;
        end
    endtask

    function automatic string tag(int op);
        case (op)
            1: return "R3";
            2: return "R7";
            3: return "R4";
            default: return "R11";
        endcase
    endfunction

    task automatic fire(int op);
        case (op)
            1: begin pin_n = 1'b0; repeat (5) tick; pin_n = 1'b1; end
            2: begin wr(1'b0, 8'h0A); end
            3: begin pwr_ok = 1'b0; repeat (5) tick; pwr_ok = 1'b1; end
            4: begin pin_n = 1'b0; wr(1'b0, 8'h0A); repeat (4) tick; pin_n = 1'b1; end
            default: begin pwr_ok = 1'b0; pin_n = 1'b0; repeat (5) tick;
                           pwr_ok = 1'b1; pin_n = 1'b1; end
        endcase
    endtask

    initial begin
        #1_500_000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit drove, saw;
        int n;
        // R1: power-on
        repeat (20) tick;
        chk("R1 reset asserted", sys_rst, 1);
        chk("R1 pin driven", pin_drive, 1);
        chk("R1 cause cleared", cause, 8'h00);
        por = 1'b0;
        wait_release(drove, saw);
        chk("R1 drive held to exit", drove, 1);
        chk("R1 cause word", cause, 8'h02);
        chk("R1 monitor on", mon_en, 1);

        // R2: hold length
        repeat (3) tick;
        wr(1'b0, 8'h0A);
        tick;
        n = 0;
        while (sys_rst && n < 100) begin n++; tick; end
        chk("R2 hold cycles", n, HOLD);
        chk("R7 software cause", cause, 8'h08);

        // table of single and combined causes
        for (int i = 0; i < 5; i++) begin
            int op;
            op = int'(VEC[i][15:12]);
            repeat (3) tick;
            fire(op);
            wait_release(drove, saw);
            chk(tag(op), saw, 1);
            chk(tag(op), cause, {24'h0, VEC[i][7:0]});
            chk(tag(op), drove, VEC[i][8]);
            chk("R9 monitor kept", mon_en, 1);
        end

        // R4: monitor not selected
        wr(1'b0, 8'h00);
        pwr_ok = 1'b0;
        repeat (10) tick;
        chk("R4 unselected no reset", sys_rst, 0);
        pwr_ok = 1'b1;
        repeat (3) tick;
        wr(1'b0, 8'h02);

        // R8: flash strobe with monitor on then off
        flash_wr = 1'b1; tick; flash_wr = 1'b0;
        repeat (HOLD + 5) tick;
        chk("R8 no reset when monitor on", sys_rst, 0);
        chk("R8 cause unchanged", cause, 8'h03);
        wr(1'b1, 8'h00);
        chk("R9 monitor write", mon_en, 0);
        flash_wr = 1'b1; tick; flash_wr = 1'b0;
        wait_release(drove, saw);
        chk("R8 flash cause", cause, 8'h10);
        chk("R9 monitor off kept", mon_en, 0);
        wr(1'b1, 8'h80);
        chk("R9 monitor re-enabled", mon_en, 1);

        // R10: write during reset
        repeat (3) tick;
        wr(1'b0, 8'h0A);
        tick; tick;
        wr(1'b1, 8'h00);
        wait_release(drove, saw);
        chk("R10 write ignored", mon_en, 1);

        // R5: stopped clock with detector enabled
        repeat (3) tick;
        wr(1'b0, 8'h06);
        repeat (40) tick;
        clk_run = 1'b0;
        #1000;
        chk("R5 reset while clock stopped", sys_rst, 1);
        chk("R5 pin not driven", pin_drive, 0);
        clk_run = 1'b1;
        wait_release(drove, saw);
        chk("R5 clock cause", cause, 8'h04);
        chk("R5 no drive", drove, 0);

        // R6: enable cleared by the reset
        repeat (40) tick;
        clk_run = 1'b0;
        #1000;
        chk("R6 detector disabled", sys_rst, 0);
        clk_run = 1'b1;
        repeat (5) tick;
        chk("R6 cause unchanged", cause, 8'h04);

        // R11: power-on dominates a pin request, restores monitor (R1)
        wr(1'b1, 8'h00);
        pin_n = 1'b0; por = 1'b1;
        repeat (20) tick;
        pin_n = 1'b1;
        repeat (3) tick;
        por = 1'b0;
        wait_release(drove, saw);
        chk("R11 power-on dominates", cause, 8'h02);
        chk("R1 monitor restored", mon_en, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule